// File: doc/BRIEF.md
# Checkpointed Register Alias Table

This block keeps the rename map of an out-of-order core: for every architectural register it records whether the newest value lives in a physical register, and if so which tag. One instruction is renamed per cycle. The two source lookups are read combinationally from the current map, and an accepted destination writes a new mapping that is visible on the next cycle. Physical tags for new destinations are supplied from outside.

Each accepted branch copies the whole map, including that branch's own destination write, into a checkpoint slot from a small pool. The identifier of the slot is returned in the same cycle. When a branch is found to be mispredicted, one recovery command restores the map from its slot. It also returns that slot and every slot taken after it to the pool, and renaming resumes on the following cycle. A correctly committed branch hands its slot back through a separate release port. A clear command, used once the machine has drained, points every register back at the architectural file and empties the pool.

Top module: `rename_ckpt_map`

## Requirements
- R1: After reset every map entry reads as not valid (value in the architectural file) and every checkpoint slot is free, so the first accepted branch receives slot 0.
- R2: The source outputs give the valid bit and tag of the entry selected by each source index from the current map, in the same cycle and with no dependence on ren_valid_i.
- R3: An accepted rename with ren_dst_en_i set makes its destination entry valid with ren_dst_tag_i from the next cycle on; a rename that is not accepted, or has no destination, leaves the map unchanged.
- R4: An accepted branch takes the lowest-numbered free slot, and ren_ckpt_o shows that number in the same cycle.
- R5: The snapshot taken for a branch holds the map after that branch's own destination write.
- R6: With rec_valid_i high, ren_stall_o is high and the rename input is ignored; on the next cycle the map equals the snapshot stored in slot rec_ckpt_i.
- R7: A recovery frees slot rec_ckpt_i and every slot allocated after it while it was live; slots allocated earlier stay taken.
- R8: With cmt_valid_i high, slot cmt_ckpt_i is free from the next cycle on.
- R9: A branch offered while all slots are taken raises ren_stall_o and changes neither the map nor the pool; non-branch renames are still accepted. A slot released in the same cycle does not lift the stall.
- R10: With arf_clear_i high, ren_stall_o is high, the rename input is ignored, and on the next cycle every entry is not valid and every slot is free; clear takes priority over a recovery in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid_i | input | 1 | An instruction is offered for renaming |
| ren_is_br_i | input | 1 | The offered instruction is a branch |
| ren_src_a_i | input | AIDX_W | First source register index |
| ren_src_b_i | input | AIDX_W | Second source register index |
| ren_dst_en_i | input | 1 | The instruction writes a destination |
| ren_dst_i | input | AIDX_W | Destination register index |
| ren_dst_tag_i | input | TAG_W | Physical tag for the destination |
| src_a_vld_o | output | 1 | First source maps to a physical register |
| src_a_tag_o | output | TAG_W | First source physical tag |
| src_b_vld_o | output | 1 | Second source maps to a physical register |
| src_b_tag_o | output | TAG_W | Second source physical tag |
| ren_stall_o | output | 1 | Offered instruction is not accepted this cycle |
| ren_ckpt_o | output | CID_W | Slot given to an accepted branch |
| rec_valid_i | input | 1 | Restore the map from a slot |
| rec_ckpt_i | input | CID_W | Slot of the mispredicted branch |
| cmt_valid_i | input | 1 | Release a slot of a committed branch |
| cmt_ckpt_i | input | CID_W | Slot to release |
| arf_clear_i | input | 1 | Point every register at the architectural file |

## Verification
The bench goes after nested recovery: it restores from a middle slot while younger slots are live. A design with the wrong age tracking would either leak the younger slots or free the older one, and a later branch would then get the wrong slot number. It fills the pool and offers a branch while a slot is released in the same cycle, where a design that lets the release bypass the full flag would hand out a slot that is still live. It also renames a branch that writes its own destination and later restores from that branch's snapshot, which shows whether the snapshot was taken before the write. A clear issued together with a recovery shows whether clear takes priority.

// File: rtl/rcm_pkg.sv
package rcm_pkg;

    typedef enum logic [1:0] {
        MAP_HOLD    = 2'd0,
        MAP_RENAME  = 2'd1,
        MAP_RESTORE = 2'd2,
        MAP_CLEAR   = 2'd3
    } map_op_e;

endpackage

// File: rtl/rcm_map.sv
module rcm_map #(
    parameter int NREG  = 32,
    parameter int TAG_W = 7,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  rcm_pkg::map_op_e            op_i,
    input  logic [IDX_W-1:0]            wr_idx_i,
    input  logic [TAG_W-1:0]            wr_tag_i,
    input  logic [NREG-1:0]             rs_vld_i,
    input  logic [NREG-1:0][TAG_W-1:0]  rs_tag_i,
    input  logic [IDX_W-1:0]            rd_a_idx_i,
    input  logic [IDX_W-1:0]            rd_b_idx_i,
    output logic                        rd_a_vld_o,
    output logic [TAG_W-1:0]            rd_a_tag_o,
    output logic                        rd_b_vld_o,
    output logic [TAG_W-1:0]            rd_b_tag_o,
    output logic [NREG-1:0]             nxt_vld_o,
    output logic [NREG-1:0][TAG_W-1:0]  nxt_tag_o
);
    import rcm_pkg::*;

    typedef struct packed {
        logic [NREG-1:0]            vld;
        logic [NREG-1:0][TAG_W-1:0] tag;
    } map_t;

    map_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (op_i)
            MAP_RENAME: begin
                st_d.vld[wr_idx_i] = 1'b1;
                st_d.tag[wr_idx_i] = wr_tag_i;
            end
            MAP_RESTORE: begin
                st_d.vld = rs_vld_i;
                st_d.tag = rs_tag_i;
            end
            MAP_CLEAR: st_d.vld = '0;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_a_vld_o = st_q.vld[rd_a_idx_i];
    assign rd_a_tag_o = st_q.tag[rd_a_idx_i];
    assign rd_b_vld_o = st_q.vld[rd_b_idx_i];
    assign rd_b_tag_o = st_q.tag[rd_b_idx_i];
    assign nxt_vld_o  = st_d.vld;
    assign nxt_tag_o  = st_d.tag;

    // R3
    rename_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == MAP_RENAME |=> st_q.vld[$past(wr_idx_i)] &&
                               st_q.tag[$past(wr_idx_i)] == $past(wr_tag_i));

    // R6
    restore_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == MAP_RESTORE |=> st_q.vld == $past(rs_vld_i) && st_q.tag == $past(rs_tag_i));

    // R10
    clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == MAP_CLEAR |=> st_q.vld == '0);

endmodule

// File: rtl/rcm_store.sv
module rcm_store #(
    parameter int NCKPT = 4,
    parameter int NREG  = 32,
    parameter int TAG_W = 7,
    localparam int CID_W = $clog2(NCKPT)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en_i,
    input  logic [CID_W-1:0]            wr_id_i,
    input  logic [NREG-1:0]             wr_vld_i,
    input  logic [NREG-1:0][TAG_W-1:0]  wr_tag_i,
    input  logic [CID_W-1:0]            rd_id_i,
    output logic [NREG-1:0]             rd_vld_o,
    output logic [NREG-1:0][TAG_W-1:0]  rd_tag_o
);
    typedef struct packed {
        logic [NREG-1:0]            vld;
        logic [NREG-1:0][TAG_W-1:0] tag;
    } snap_t;

    snap_t [NCKPT-1:0] st_d, st_q;
    logic  [NCKPT-1:0] slot_we;

    for (genvar s = 0; s < NCKPT; s++) begin : g_slot
        assign slot_we[s] = wr_en_i && (wr_id_i == CID_W'(s));
    end

    always_comb begin
        st_d = st_q;
        for (int s = 0; s < NCKPT; s++) begin
            if (slot_we[s]) begin
                st_d[s].vld = wr_vld_i;
                st_d[s].tag = wr_tag_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_vld_o = st_q[rd_id_i].vld;
    assign rd_tag_o = st_q[rd_id_i].tag;

    // R5
    snap_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> st_q[$past(wr_id_i)].vld == $past(wr_vld_i) &&
                    st_q[$past(wr_id_i)].tag == $past(wr_tag_i));

endmodule

// File: rtl/rcm_pool.sv
module rcm_pool #(
    parameter int NCKPT = 4,
    localparam int CID_W = $clog2(NCKPT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             alloc_i,
    input  logic             rec_i,
    input  logic [CID_W-1:0] rec_id_i,
    input  logic             cmt_i,
    input  logic [CID_W-1:0] cmt_id_i,
    output logic             full_o,
    output logic [CID_W-1:0] alloc_id_o
);
    // younger[i][j] set: slot j was taken while slot i was live
    typedef struct packed {
        logic [NCKPT-1:0]             live;
        logic [NCKPT-1:0][NCKPT-1:0]  younger;
    } pool_t;

    pool_t            st_d, st_q;
    logic [NCKPT-1:0] kill;

    always_comb begin
        alloc_id_o = '0;
        for (int i = NCKPT - 1; i >= 0; i--) begin
            if (!st_q.live[i]) alloc_id_o = CID_W'(i);
        end
    end

    assign full_o = &st_q.live;

    always_comb begin
        kill = '0;
        if (rec_i) begin
            kill = st_q.younger[rec_id_i];
            kill[rec_id_i] = 1'b1;
        end
    end

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d.live = '0;
        end else begin
            st_d.live = st_q.live & ~kill;
            if (cmt_i) st_d.live[cmt_id_i] = 1'b0;
            if (alloc_i) begin
                st_d.live[alloc_id_o] = 1'b1;
                st_d.younger[alloc_id_o] = '0;
                for (int i = 0; i < NCKPT; i++) begin
                    st_d.younger[i][alloc_id_o] = st_q.live[i];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R9
    no_alloc_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_i |-> !full_o);

    // R4
    alloc_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_i && !clear_i && !rec_i |=> st_q.live[$past(alloc_id_o)]);

    // R7
    rec_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_i && !clear_i |-> st_q.live[rec_id_i]);

    // R7
    rec_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_i && !clear_i |=> !st_q.live[$past(rec_id_i)]);

    // R8
    cmt_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_i && !(alloc_i && alloc_id_o == cmt_id_i) |=> !st_q.live[$past(cmt_id_i)]);

    // R10
    clear_pool_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> st_q.live == '0);

endmodule

// File: rtl/rename_ckpt_map.sv
module rename_ckpt_map #(
    parameter int NREG  = 32,
    parameter int TAG_W = 7,
    parameter int NCKPT = 4,
    localparam int AIDX_W = $clog2(NREG),
    localparam int CID_W  = $clog2(NCKPT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ren_valid_i,
    input  logic              ren_is_br_i,
    input  logic [AIDX_W-1:0] ren_src_a_i,
    input  logic [AIDX_W-1:0] ren_src_b_i,
    input  logic              ren_dst_en_i,
    input  logic [AIDX_W-1:0] ren_dst_i,
    input  logic [TAG_W-1:0]  ren_dst_tag_i,
    output logic              src_a_vld_o,
    output logic [TAG_W-1:0]  src_a_tag_o,
    output logic              src_b_vld_o,
    output logic [TAG_W-1:0]  src_b_tag_o,
    output logic              ren_stall_o,
    output logic [CID_W-1:0]  ren_ckpt_o,
    input  logic              rec_valid_i,
    input  logic [CID_W-1:0]  rec_ckpt_i,
    input  logic              cmt_valid_i,
    input  logic [CID_W-1:0]  cmt_ckpt_i,
    input  logic              arf_clear_i
);
    import rcm_pkg::*;

    logic                       pool_full;
    logic [CID_W-1:0]           alloc_id;
    logic                       accept, take_snap;
    map_op_e                    map_op;
    logic [NREG-1:0]            nxt_vld, rs_vld;
    logic [NREG-1:0][TAG_W-1:0] nxt_tag, rs_tag;

    assign ren_stall_o = rec_valid_i | arf_clear_i | (ren_valid_i & ren_is_br_i & pool_full);
    assign accept      = ren_valid_i & ~ren_stall_o;
    assign take_snap   = accept & ren_is_br_i;
    assign ren_ckpt_o  = alloc_id;

    always_comb begin
        if (arf_clear_i)               map_op = MAP_CLEAR;
        else if (rec_valid_i)          map_op = MAP_RESTORE;
        else if (accept && ren_dst_en_i) map_op = MAP_RENAME;
        else                           map_op = MAP_HOLD;
    end

    rcm_map #(.NREG(NREG), .TAG_W(TAG_W)) u_map (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_i       (map_op),
        .wr_idx_i   (ren_dst_i),
        .wr_tag_i   (ren_dst_tag_i),
        .rs_vld_i   (rs_vld),
        .rs_tag_i   (rs_tag),
        .rd_a_idx_i (ren_src_a_i),
        .rd_b_idx_i (ren_src_b_i),
        .rd_a_vld_o (src_a_vld_o),
        .rd_a_tag_o (src_a_tag_o),
        .rd_b_vld_o (src_b_vld_o),
        .rd_b_tag_o (src_b_tag_o),
        .nxt_vld_o  (nxt_vld),
        .nxt_tag_o  (nxt_tag)
    );

    rcm_store #(.NCKPT(NCKPT), .NREG(NREG), .TAG_W(TAG_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (take_snap),
        .wr_id_i  (alloc_id),
        .wr_vld_i (nxt_vld),
        .wr_tag_i (nxt_tag),
        .rd_id_i  (rec_ckpt_i),
        .rd_vld_o (rs_vld),
        .rd_tag_o (rs_tag)
    );

    rcm_pool #(.NCKPT(NCKPT)) u_pool (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (arf_clear_i),
        .alloc_i    (take_snap),
        .rec_i      (rec_valid_i),
        .rec_id_i   (rec_ckpt_i),
        .cmt_i      (cmt_valid_i),
        .cmt_id_i   (cmt_ckpt_i),
        .full_o     (pool_full),
        .alloc_id_o (alloc_id)
    );

    // R6
    rec_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid_i |-> map_op != MAP_RENAME && !take_snap);

endmodule

// File: tb/test_rename_ckpt_map.sv
module test_rename_ckpt_map;
    localparam int CLK_PERIOD = 10;
    localparam int NREG = 32, TAG_W = 7, NCKPT = 4;
    localparam int AIDX_W = $clog2(NREG), CID_W = $clog2(NCKPT);

    logic clk = 0, rst_n = 0;
    logic ren_valid, ren_is_br, ren_dst_en, rec_valid, cmt_valid, arf_clear;
    logic [AIDX_W-1:0] src_a, src_b, dst;
    logic [TAG_W-1:0] dst_tag;
    logic [CID_W-1:0] rec_id, cmt_id;
    logic a_vld, b_vld, stall;
    logic [TAG_W-1:0] a_tag, b_tag;
    logic [CID_W-1:0] ckpt;

    rename_ckpt_map i_rename_ckpt_map (
        .clk(clk), .rst_n(rst_n), .ren_valid_i(ren_valid), .ren_is_br_i(ren_is_br),
        .ren_src_a_i(src_a), .ren_src_b_i(src_b), .ren_dst_en_i(ren_dst_en),
        .ren_dst_i(dst), .ren_dst_tag_i(dst_tag), .src_a_vld_o(a_vld), .src_a_tag_o(a_tag),
        .src_b_vld_o(b_vld), .src_b_tag_o(b_tag), .ren_stall_o(stall), .ren_ckpt_o(ckpt),
        .rec_valid_i(rec_valid), .rec_ckpt_i(rec_id), .cmt_valid_i(cmt_valid),
        .cmt_ckpt_i(cmt_id), .arf_clear_i(arf_clear));

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_fail = 0;
    bit m_vld [NREG];
    int m_tag [NREG];
    bit c_vld [NCKPT][NREG];
    int c_tag [NCKPT][NREG];
    int order [$];

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit is_live(int id);
        foreach (order[k]) if (order[k] == id) return 1;
        return 0;
    endfunction

    function automatic int first_free();
        for (int i = 0; i < NCKPT; i++) if (!is_live(i)) return i;
        return -1;
    endfunction

    task automatic quiet();
        ren_valid = 0; ren_is_br = 0; ren_dst_en = 0; dst = 0; dst_tag = 0;
        src_a = 0; src_b = 0; rec_valid = 0; rec_id = 0; cmt_valid = 0; cmt_id = 0;
        arf_clear = 0;
    endtask

    // check outputs against model, clock once, update model
    task automatic cycle();
        bit full, acc, exp_stall;
        string sreq;
        #1;
        full = (order.size() == NCKPT);
        exp_stall = rec_valid | arf_clear | (ren_valid & ren_is_br & full);
        sreq = arf_clear ? "R10" : (rec_valid ? "R6" : "R9");
        chk(sreq, "stall", stall, exp_stall);
        chk("R2", "src_a valid", a_vld, m_vld[src_a]);
        chk("R2", "src_b valid", b_vld, m_vld[src_b]);
        if (m_vld[src_a]) chk("R2", "src_a tag", a_tag, m_tag[src_a]);
        if (m_vld[src_b]) chk("R2", "src_b tag", b_tag, m_tag[src_b]);
        acc = ren_valid & !exp_stall;
        if (acc && ren_is_br) chk("R4", "slot id", ckpt, first_free());
        @(posedge clk);
        if (arf_clear) begin
            foreach (m_vld[r]) m_vld[r] = 0;
            order.delete();
        end else if (rec_valid) begin
            foreach (m_vld[r]) begin m_vld[r] = c_vld[rec_id][r]; m_tag[r] = c_tag[rec_id][r]; end
            for (int k = 0; k < order.size(); k++)
                if (order[k] == rec_id) begin
                    while (order.size() > k) void'(order.pop_back());
                    break;
                end
        end else begin
            int nid;
            nid = first_free();
            if (acc && ren_dst_en) begin m_vld[dst] = 1; m_tag[dst] = dst_tag; end
            if (acc && ren_is_br) begin
                foreach (m_vld[r]) begin c_vld[nid][r] = m_vld[r]; c_tag[nid][r] = m_tag[r]; end
                order.push_back(nid);
            end
        end
        if (cmt_valid && !arf_clear)
            for (int k = 0; k < order.size(); k++)
                if (order[k] == cmt_id) begin order.delete(k); break; end
        @(negedge clk);
    endtask

    task automatic ren(bit br, bit den, int d, int t);
        quiet();
        ren_valid = 1; ren_is_br = br; ren_dst_en = den; dst = d[AIDX_W-1:0];
        dst_tag = t[TAG_W-1:0]; src_a = d[AIDX_W-1:0]; src_b = AIDX_W'(d + 1);
        cycle();
    endtask

    task automatic scan(string req);
        for (int i = 0; i < NREG / 2; i++) begin
            quiet();
            src_a = AIDX_W'(2 * i); src_b = AIDX_W'(2 * i + 1);
            #1;
            chk(req, "scan valid a", a_vld, m_vld[2 * i]);
            chk(req, "scan valid b", b_vld, m_vld[2 * i + 1]);
            if (m_vld[2 * i]) chk(req, "scan tag a", a_tag, m_tag[2 * i]);
            if (m_vld[2 * i + 1]) chk(req, "scan tag b", b_tag, m_tag[2 * i + 1]);
            cycle();
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        int s1;
        quiet();
        foreach (m_vld[r]) begin m_vld[r] = 0; m_tag[r] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: map empty, first branch gets slot 0
        scan("R1");
        quiet(); ren_valid = 1; ren_is_br = 1; #1;
        chk("R1", "first slot", ckpt, 0);
        cycle();
        // R3: plain renames, some with no destination or not valid
        for (int i = 0; i < 20; i++) ren(0, (i % 3) != 0, i, 10 + i);
        quiet(); ren_dst_en = 1; dst = 5; dst_tag = 77; cycle();
        scan("R3");
        // R5: branch writes its own destination; slot 1
        ren(1, 1, 9, 99);
        ren(0, 1, 9, 3);
        ren(1, 0, 0, 0);          // slot 2, younger
        ren(0, 1, 4, 44);
        quiet(); rec_valid = 1; rec_id = 1; ren_valid = 1; ren_dst_en = 1; dst = 4; dst_tag = 1;
        cycle();
        quiet(); src_a = 9; #1;
        chk("R5", "own dst in snapshot valid", a_vld, 1);
        chk("R5", "own dst in snapshot tag", a_tag, 99);
        scan("R6");
        // R7: slots 1 and 2 freed, slot 0 kept -> next branches get 1 then 2
        quiet(); ren_valid = 1; ren_is_br = 1; #1;
        chk("R7", "freed slot reused", ckpt, 1);
        cycle();
        ren(1, 1, 2, 20);
        ren(1, 1, 3, 21);         // slot 3 -> pool full
        // R9: full pool stalls branch, commit same cycle does not lift it
        quiet(); ren_valid = 1; ren_is_br = 1; ren_dst_en = 1; dst = 7; dst_tag = 70;
        cmt_valid = 1; cmt_id = 0; #1;
        chk("R9", "full stall", stall, 1);
        cycle();
        quiet(); src_a = 7; #1;
        chk("R9", "stalled branch no write", a_vld, m_vld[7]);
        cycle();
        ren(0, 1, 6, 60);
        // R8: slot 0 released by commit
        quiet(); ren_valid = 1; ren_is_br = 1; #1;
        chk("R8", "released slot reused", ckpt, 0);
        cycle();
        // R10: clear with recovery in the same cycle
        quiet(); arf_clear = 1; rec_valid = 1; rec_id = 2; cycle();
        scan("R10");
        quiet(); ren_valid = 1; ren_is_br = 1; #1;
        chk("R10", "pool empty after clear", ckpt, 0);
        cycle();
        // random mixed traffic
        for (int n = 0; n < 3000; n++) begin
            quiet();
            ren_valid = ($urandom % 4) != 0;
            ren_is_br = ($urandom % 6) == 0;
            ren_dst_en = ($urandom % 3) != 0;
            dst = AIDX_W'($urandom); dst_tag = TAG_W'($urandom);
            src_a = AIDX_W'($urandom); src_b = AIDX_W'($urandom);
            if (order.size() > 0 && ($urandom % 25) == 0) begin
                s1 = $urandom % order.size();
                rec_valid = 1; rec_id = CID_W'(order[s1]);
            end
            if (order.size() > 0 && ($urandom % 12) == 0) begin
                cmt_valid = 1; cmt_id = CID_W'(order[0]);
            end
            arf_clear = ($urandom % 400) == 0;
            cycle();
        end
        scan("R6");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule